// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one down-counter timer that software programs through a small word-addressed register port. A prescaler divides the system clock by 1, 16 or 256 to make count ticks. The counter runs 16 or 32 bits wide and has three modes. In periodic mode it reloads from a software value. In one-shot mode it stops at zero and switches itself off. In free-running mode it wraps to all ones of the selected width.

Software can set the reload value in two ways. An immediate load also restarts the count at once. A background load changes only the value used at the next wrap. Every wrap sets a raw interrupt flag. Software can read the flag directly or through the enable mask, and a write to the clear offset drops it. The single interrupt output is a level signal.

Top module: `interval_timer`

## Requirements
- R1: After reset the control word reads 0x20: interrupt enable (bit 5) is set and the timer enable (bit 7) is clear. The reload value, the counter and the raw flag all read 0, and `irq` is low.
- R2: Control bits 3:2 select the tick rate. 00 ticks every clock, 01 every 16 clocks and 10 every 256 clocks. 11 behaves like 00. Ticks occur only while bit 7 is set.
- R3: Periodic mode is bit 6 set with bit 0 clear. A tick that finds the counter at zero sets the raw flag and reloads the counter with the reload value, so one period lasts reload+1 ticks.
- R4: One-shot mode is bit 0 set. A tick that finds the counter at zero sets the raw flag and leaves the counter at zero. It also clears control bit 7, so the timer stops.
- R5: Free-running mode is bits 0 and 6 both clear. A tick at zero sets the raw flag and reloads the counter with 0xFFFF, or with 0xFFFFFFFF when bit 1 is set.
- R6: Control bit 1 selects a 32-bit counter, and clear selects 16 bits. In 16-bit mode the counter keeps only the low 16 bits of any value it takes. A control write that narrows the width truncates the counter at once.
- R7: A write to offset 0 stores the reload value and loads the counter with it (masked to the width) in the same edge. A write to offset 6 stores only the reload value, and the count carries on.
- R8: Reads of offset 0 and offset 6 both return the stored reload value. Offset 1 returns the counter. Writes to offset 1 change nothing.
- R9: Offset 4 returns the raw flag in bit 0. Offset 5 returns the raw flag ANDed with control bit 5. `irq` equals the raw flag AND bit 5.
- R10: Any write to offset 3 clears the raw flag. If a wrap happens in the same edge, the flag stays set.
- R11: A control write (offset 2) restarts the prescaler phase. The first tick after it comes exactly one full divide interval later, and no tick occurs in the edge of the write itself.
- R12: Read data is registered. `reg_rdata` shows the register selected by `reg_addr` one clock after the address is presented. Offset 3 and offset 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (3) | Word offset of the register |
| reg_we | input | 1 | Write strobe for one clock |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt, registered |

## Verification
A wrong prescaler phase or a wrong tick decision shows up as a count that is off by one. That error is visible on the next read of offset 1, and the bench catches it by stopping the timer exactly one clock before and one clock after each expected tick. A wrong reload choice or a wrong one-shot stop changes the interval between `irq` edges. It also changes the enable bit read back, so the error appears within one period. The bench runs a behavioural model of the register state alongside the design and compares `irq` and `reg_rdata` on every clock. Any divergence in hidden state therefore appears as soon as it reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CTRL_W = 8;

  // word offsets
  localparam int OFS_LOAD   = 0;
  localparam int OFS_VALUE  = 1;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_ICLR   = 3;
  localparam int OFS_RAW    = 4;
  localparam int OFS_MASKED = 5;
  localparam int OFS_BGLOAD = 6;

  typedef struct packed {
    logic       en;        // bit 7
    logic       periodic;  // bit 6
    logic       ie;        // bit 5
    logic       spare;     // bit 4
    logic [1:0] psel;      // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

  localparam logic [1:0] PS_DIV1   = 2'b00;
  localparam logic [1:0] PS_DIV16  = 2'b01;
  localparam logic [1:0] PS_DIV256 = 2'b10;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int MID_LOG = 4,
  parameter int HI_LOG  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);
  import tmr_pkg::*;

  localparam int PH_W = HI_LOG;
  localparam logic [PH_W-1:0] LAST_MID = PH_W'((1 << MID_LOG) - 1);
  localparam logic [PH_W-1:0] LAST_HI  = PH_W'((1 << HI_LOG) - 1);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] last;

  always_comb begin
    case (psel)
      PS_DIV16:  last = LAST_MID;
      PS_DIV256: last = LAST_HI;
      default:   last = '0;
    endcase
  end

  assign tick = run && !restart && (phase == last);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) begin
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wide,
  input  logic              oneshot,
  input  logic              freerun,
  input  logic              load_now,
  input  logic [DATA_W-1:0] load_val,
  input  logic              remask,
  input  logic              wide_new,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count,
  output logic              wrap
);

  localparam logic [DATA_W-1:0] MASK_WIDE   = '1;
  localparam logic [DATA_W-1:0] MASK_NARROW = DATA_W'((64'd1 << NARROW_W) - 64'd1);

  logic [DATA_W-1:0] mask_cur;
  logic [DATA_W-1:0] mask_new;
  logic [DATA_W-1:0] wrap_val;
  logic              at_zero;

  assign mask_cur = wide ? MASK_WIDE : MASK_NARROW;
  assign mask_new = wide_new ? MASK_WIDE : MASK_NARROW;
  assign at_zero  = (count == '0);
  assign wrap     = tick && at_zero && !load_now;

  always_comb begin
    if (oneshot) begin
      wrap_val = '0;
    end else if (freerun) begin
      wrap_val = mask_cur;
    end else begin
      wrap_val = reload_val & mask_cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_now) begin
      count <= load_val & mask_cur;
    end else if (remask) begin
      count <= count & mask_new;
    end else if (wrap) begin
      count <= wrap_val;
    end else if (tick) begin
      count <= count - DATA_W'(1);
    end
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] count,
  input  logic              wrap,
  output tmr_pkg::ctrl_t    ctrl_q,
  output tmr_pkg::ctrl_t    ctrl_wval,
  output logic              ctrl_wr,
  output logic              load_now,
  output logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ICLR   = ADDR_W'(OFS_ICLR);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_BGLOAD = ADDR_W'(OFS_BGLOAD);

  ctrl_t             ctrl_d;
  logic              raw_q, raw_d;
  logic              bg_wr, clr_wr;
  logic [DATA_W-1:0] rd_d;

  assign ctrl_wval = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign ctrl_wr   = reg_we && (reg_addr == A_CTRL);
  assign load_now  = reg_we && (reg_addr == A_LOAD);
  assign bg_wr     = reg_we && (reg_addr == A_BGLOAD);
  assign clr_wr    = reg_we && (reg_addr == A_ICLR);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = ctrl_wval;
    end else if (wrap && ctrl_q.oneshot) begin
      ctrl_d.en = 1'b0;
    end
  end

  always_comb begin
    if (wrap) begin
      raw_d = 1'b1;
    end else if (clr_wr) begin
      raw_d = 1'b0;
    end else begin
      raw_d = raw_q;
    end
  end

  always_comb begin
    case (reg_addr)
      A_LOAD, A_BGLOAD: rd_d = reload_q;
      A_VALUE:          rd_d = count;
      A_CTRL:           rd_d = DATA_W'(ctrl_q);
      A_RAW:            rd_d = DATA_W'(raw_q);
      A_MASKED:         rd_d = DATA_W'(raw_q & ctrl_q.ie);
      default:          rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= ctrl_t'(CTRL_RST);
      raw_q     <= 1'b0;
      reload_q  <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      raw_q     <= raw_d;
      reg_rdata <= rd_d;
      irq       <= raw_d & ctrl_d.ie;
      if (load_now || bg_wr) begin
        reload_q <= reg_wdata;
      end
    end
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int ADDR_W   = 3,
  parameter int MID_LOG  = 4,
  parameter int HI_LOG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import tmr_pkg::*;

  ctrl_t             ctrl_q;
  ctrl_t             ctrl_wval;
  logic              ctrl_wr;
  logic              load_now;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count;
  logic              tick;
  logic              wrap;
  logic              freerun;

  assign freerun = !ctrl_q.periodic && !ctrl_q.oneshot;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .count     (count),
    .wrap      (wrap),
    .ctrl_q    (ctrl_q),
    .ctrl_wval (ctrl_wval),
    .ctrl_wr   (ctrl_wr),
    .load_now  (load_now),
    .reload_q  (reload_q),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  tmr_prescaler #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) u_ps (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.en),
    .restart (ctrl_wr),
    .psel    (ctrl_q.psel),
    .tick    (tick)
  );

  tmr_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .wide       (ctrl_q.wide),
    .oneshot    (ctrl_q.oneshot),
    .freerun    (freerun),
    .load_now   (load_now),
    .load_val   (reg_wdata),
    .remask     (ctrl_wr),
    .wide_new   (ctrl_wval.wide),
    .reload_val (reload_q),
    .count      (count),
    .wrap       (wrap)
  );

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic              ctrl_en,
  input logic              ctrl_ie,
  input logic              ctrl_wide,
  input logic              ctrl_oneshot,
  input logic [DATA_W-1:0] count,
  input logic              tick,
  input logic              wrap
);

  localparam logic [DATA_W-1:0] NMASK = DATA_W'((64'd1 << NARROW_W) - 64'd1);

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl_ie) else $error("irq without enable"); // R9

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_W'(3) && !wrap) |=> !irq) else $error("clear ignored"); // R10

  AST_VALUE_READONLY: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_W'(1) && !tick) |=> (count == $past(count))) else $error("value written"); // R8

  AST_LOAD_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_W'(0)) |=>
      (count == ($past(ctrl_wide) ? $past(reg_wdata) : ($past(reg_wdata) & NMASK)))) else $error("load lost"); // R7

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (wrap && ctrl_oneshot && !(reg_we && reg_addr == ADDR_W'(2))) |=> (!ctrl_en && count == '0)) else $error("one-shot ran on"); // R4

  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wide |-> ((count & ~NMASK) == '0)) else $error("narrow overflow"); // R6

  AST_TICK_ENABLED: assert property (@(posedge clk) disable iff (rst)
    tick |-> ctrl_en) else $error("tick while stopped"); // R2

endmodule

bind interval_timer interval_timer_chk #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_addr     (reg_addr),
  .reg_we       (reg_we),
  .reg_wdata    (reg_wdata),
  .irq          (irq),
  .ctrl_en      (ctrl_q.en),
  .ctrl_ie      (ctrl_q.ie),
  .ctrl_wide    (ctrl_q.wide),
  .ctrl_oneshot (ctrl_q.oneshot),
  .count        (count),
  .tick         (tick),
  .wrap         (wrap)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_ctrl;
  logic [31:0] m_load, m_cnt, m_rd;
  logic        m_raw, m_irq;
  int          m_ph;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 8'h20; m_load = 0; m_cnt = 0; m_raw = 0; m_ph = 0;
      m_rd = 0; m_irq = 0;
    end else begin
      int div;
      bit run, cw, tk, lw, wrp, freerun;
      logic [31:0] mask, n_cnt, n_load, rd_n;
      logic [7:0] n_ctrl;
      logic n_raw;
      int n_ph;
      div = (m_ctrl[3:2] == 2'b01) ? 16 : (m_ctrl[3:2] == 2'b10) ? 256 : 1;
      run = m_ctrl[7];
      cw = reg_we && reg_addr == 3'd2;
      lw = reg_we && reg_addr == 3'd0;
      tk = run && !cw && (m_ph == div - 1);
      mask = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      freerun = !m_ctrl[0] && !m_ctrl[6];
      wrp = tk && (m_cnt == 0) && !lw;
      case (reg_addr)
        3'd0, 3'd6: rd_n = m_load;
        3'd1: rd_n = m_cnt;
        3'd2: rd_n = {24'd0, m_ctrl};
        3'd4: rd_n = {31'd0, m_raw};
        3'd5: rd_n = {31'd0, m_raw & m_ctrl[5]};
        default: rd_n = 0;
      endcase
      n_ph = (!run || cw || tk) ? 0 : m_ph + 1;
      if (lw) n_cnt = reg_wdata & mask;
      else if (cw) n_cnt = reg_wdata[1] ? m_cnt : (m_cnt & 32'hFFFF);
      else if (wrp) n_cnt = m_ctrl[0] ? 0 : (freerun ? mask : (m_load & mask));
      else if (tk) n_cnt = m_cnt - 1;
      else n_cnt = m_cnt;
      if (cw) n_ctrl = reg_wdata[7:0];
      else if (wrp && m_ctrl[0]) n_ctrl = m_ctrl & 8'h7F;
      else n_ctrl = m_ctrl;
      n_load = (reg_we && (reg_addr == 3'd0 || reg_addr == 3'd6)) ? reg_wdata : m_load;
      n_raw = wrp ? 1'b1 : ((reg_we && reg_addr == 3'd3) ? 1'b0 : m_raw);
      m_ph = n_ph; m_cnt = n_cnt; m_ctrl = n_ctrl; m_load = n_load; m_raw = n_raw;
      m_rd = rd_n; m_irq = n_raw & n_ctrl[5];
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (reg_rdata !== m_rd) begin
        failures++;
        $display("FAIL R12 model rdata actual=%h expected=%h t=%0t", reg_rdata, m_rd, $time);
      end
      checks++;
      if (irq !== m_irq) begin
        failures++;
        $display("FAIL R9 model irq actual=%b expected=%b t=%0t", irq, m_irq, $time);
      end
    end
  end

  // ---------------- helpers (called at a falling edge) ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // run with a control word for n clocks, then stop and read the counter
  task automatic ps_run(input logic [7:0] c, input int n, input logic [31:0] exp, input string tag);
    wr(3'd0, 32'd5);
    wr(3'd2, {24'd0, c});
    repeat (n) @(negedge clk);
    wr(3'd2, 32'd0);
    rd(3'd1, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(3'd2, 32'h20, "R1 ctrl reset");
    rd(3'd1, 32'd0, "R1 value reset");
    rd(3'd0, 32'd0, "R1 load reset");
    rd(3'd4, 32'd0, "R1 raw reset");
    rd(3'd7, 32'd0, "R12 unused offset reads zero");

    // R7 / R8 load paths
    wr(3'd0, 32'h10);
    rd(3'd1, 32'h10, "R7 immediate load sets counter");
    rd(3'd6, 32'h10, "R8 bg offset reads reload");
    wr(3'd6, 32'h55);
    rd(3'd1, 32'h10, "R7 background load leaves counter");
    rd(3'd0, 32'h55, "R8 load offset reads reload");
    wr(3'd1, 32'h1234);
    rd(3'd1, 32'h10, "R8 value write ignored");

    // R3 periodic, R9, R10
    wr(3'd0, 32'd3);
    wr(3'd2, 32'hE2);
    wait_irq(n);
    chk("R3 first period ticks", n, 32'd4);
    wr(3'd3, 32'd0);
    chk("R10 clear drops irq", {31'd0, irq}, 32'd0);
    wait_irq(n);
    chk("R3 reload period", n, 32'd3);
    wr(3'd2, 32'h02);
    chk("R9 irq masked off", {31'd0, irq}, 32'd0);
    rd(3'd4, 32'd1, "R9 raw stays set");
    rd(3'd5, 32'd0, "R9 masked reads zero");
    wr(3'd2, 32'h22);
    chk("R9 irq with enable", {31'd0, irq}, 32'd1);
    rd(3'd5, 32'd1, "R9 masked equals raw");
    wr(3'd3, 32'd0);
    rd(3'd4, 32'd0, "R10 raw cleared");

    // R4 one-shot
    wr(3'd2, 32'h00);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA1);
    wait_irq(n);
    chk("R4 one-shot ticks", n, 32'd3);
    rd(3'd2, 32'h21, "R4 enable cleared");
    repeat (5) @(negedge clk);
    rd(3'd1, 32'd0, "R4 counter held at zero");

    // R5 free-running
    wr(3'd2, 32'h00);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd1);
    wr(3'd2, 32'hA0);
    wait_irq(n);
    chk("R5 narrow wrap ticks", n, 32'd2);
    wr(3'd2, 32'h20);
    rd(3'd1, 32'h0000FFFF, "R5 narrow wraps to all ones");
    wr(3'd2, 32'h02);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd2, 32'hA2);
    wait_irq(n);
    chk("R5 wide wrap ticks", n, 32'd1);
    wr(3'd2, 32'h22);
    rd(3'd1, 32'hFFFFFFFF, "R5 wide wraps to all ones");

    // R6 width
    wr(3'd2, 32'h00);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h12345);
    rd(3'd1, 32'h2345, "R6 narrow load truncated");
    rd(3'd0, 32'h12345, "R6 reload kept whole");
    wr(3'd2, 32'h02);
    wr(3'd0, 32'h12345);
    rd(3'd1, 32'h12345, "R6 wide load");
    wr(3'd2, 32'h00);
    rd(3'd1, 32'h2345, "R6 narrowing truncates");

    // R2 prescaler / R11 phase restart
    ps_run(8'h84, 15, 32'd5, "R2 div16 no tick before 16");
    ps_run(8'h84, 16, 32'd4, "R2 div16 tick at 16");
    ps_run(8'h88, 255, 32'd5, "R2 div256 no tick before 256");
    ps_run(8'h88, 256, 32'd4, "R2 div256 tick at 256");
    ps_run(8'h8C, 3, 32'd2, "R2 code 11 divides by one");
    ps_run(8'h80, 3, 32'd2, "R2 div1");
    ps_run(8'h04, 40, 32'd5, "R2 disabled never ticks");
    wr(3'd0, 32'd5);
    wr(3'd2, 32'h84);
    repeat (7) @(negedge clk);
    wr(3'd2, 32'h84);
    repeat (15) @(negedge clk);
    wr(3'd2, 32'h00);
    rd(3'd1, 32'd5, "R11 control write restarts phase");

    // R10 wrap wins over clear
    wr(3'd0, 32'd0);
    wr(3'd2, 32'hE2);
    wr(3'd3, 32'd0);
    chk("R10 wrap beats clear", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h00);
    wr(3'd3, 32'd0);
    chk("R10 final clear", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule